// File: doc/BRIEF.md
# MII Management Frame Unit

This block gives a host a single 32-bit management frame register through which it issues clause-22-style read and write commands to an internal PHY register file of 32 sixteen-bit registers. A write of a command word is decoded and carried out in the same clock cycle. The word is then stored back with a completion flag set. For a read, the stored word carries the PHY register contents in its low 16 bits. The register file models the usual self-clearing control bits and tracks a link input.

Two more host registers sit beside the frame register. One is a configuration word whose two transceiver-present bits the host cannot change. The other is a 16-bit event status word. It is loaded with all ones whenever the link input changes and is cleared when the host reads it. The serial pin timing of a real management bus and any external PHY are not modelled. Host reads are combinational from the selected register.

Top module: `mii_mgmt_unit`

## Requirements
- R1: A frame write performs a PHY access only if bits 31:30 equal 01 and bits 27:23 equal the PHY address parameter (default 1). Any other word performs no access to any PHY register, and the word is stored with bit 16 set.
- R2: Every frame write stores the written word with bit 16 forced to 1. All other bits keep their written values, except bits 15:0 of an accepted read.
- R3: For an accepted command, opcode (bits 29:28) 01 writes bits 15:0 into the PHY register selected by bits 22:18. Opcode 10 stores that register's current value in bits 15:0 of the frame register.
- R4: For an accepted command, opcodes 00 and 11 change no PHY register, and the data bits are stored as written.
- R5: A write to PHY register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R6: A write to PHY register 0 with bit 9 set stores the value with bit 9 cleared and sets bit 5 of register 1. When the link input is high, it also sets bit 2 of register 1 and bit 8 of register 5.
- R7: After reset the frame register is 0. Register 4 holds 0x0100. Register 1 holds 0x4028, with bit 2 also set if the link input was high during reset. Register 5 holds 0x0100 if the link was high and 0 otherwise. All other PHY registers hold 0.
- R8: The host address selects 0 for the frame register, 1 for configuration and 2 for status. Address 3 reads as 0. Configuration bits 9:8 ignore host writes and reset to 01. All other configuration bits are writable and reset to 0.
- R9: One clock after the link input changes, bit 2 of register 1 and bit 8 of register 5 equal the new link level, and the status word is 0xFFFF.
- R10: A status read returns the current value, and the status word is 0 from the next cycle on. If a link change happens in the same cycle as the read, the status word becomes 0xFFFF instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link level reported by the PHY model |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (clears status on address 2) |
| addr | input | 2 | Host register select |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, combinational |

## Verification
A wrong PHY register value stays hidden until the host reads that register back through an accepted read command. From that point it appears in bits 15:0 of the frame register one cycle after the command. A missed link event shows up in the status word and in register 1 on the very next cycle. A bad decode of the start, address or opcode fields shows either as a missing completion bit right after the write, or as a corrupted register found by a later readback. For this reason the random sequence ends by reading back every PHY register.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int PHY_DW = 16;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [REG_AW-1:0] phy;
    logic [REG_AW-1:0] ra;
    logic [1:0]        ta;
    logic [PHY_DW-1:0] data;
  } mgmt_cmd_t;

  localparam logic [1:0] ST_VALID = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_ANEN_BIT    = 12;
  localparam int CTL_RESTART_BIT = 9;
  localparam int STS_ANDONE_BIT  = 5;
  localparam int STS_LINK_BIT    = 2;
  localparam int LPA_FD100_BIT   = 8;

  localparam logic [15:0] STS_BASE  = 16'h4028;
  localparam logic [15:0] ADV_RESET = 16'h0100;
  localparam logic [31:0] CFG_RESET = 32'h0000_0100;
  localparam logic [31:0] CFG_RO    = 32'h0000_0300;

  function automatic logic [PHY_DW-1:0] phy_reset_value(input int idx, input logic link);
    logic [PHY_DW-1:0] v;
    v = '0;
    case (idx)
      1: begin
        v = STS_BASE;
        v[STS_LINK_BIT] = link;
      end
      4: v = ADV_RESET;
      5: v[LPA_FD100_BIT] = link;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [PHY_DW-1:0] ctrl_store_value(input logic [PHY_DW-1:0] d);
    logic [PHY_DW-1:0] v;
    v = d;
    if (d[CTL_RESET_BIT]) begin
      v[CTL_RESET_BIT] = 1'b0;
      v[CTL_ANEN_BIT]  = 1'b1;
    end
    v[CTL_RESTART_BIT] = 1'b0;
    return v;
  endfunction

  function automatic logic [31:0] cfg_merge(input logic [31:0] old_v, input logic [31:0] new_v);
    return (new_v & ~CFG_RO) | (old_v & CFG_RO);
  endfunction

endpackage

// File: rtl/mii_cmd_decode.sv
module mii_cmd_decode
  import mii_mgmt_pkg::*;
#(
  parameter logic [REG_AW-1:0] PHY_ADDR = 5'd1
) (
  input  logic              frame_wr,
  input  logic [1:0]        st,
  input  logic [1:0]        op,
  input  logic [REG_AW-1:0] phy,
  output logic              accept,
  output logic              phy_wr,
  output logic              phy_rd
);

  always_comb begin
    accept = frame_wr && (st == ST_VALID) && (phy == PHY_ADDR);
    phy_wr = accept && (op == OP_WRITE);
    phy_rd = accept && (op == OP_READ);
  end

endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
  import mii_mgmt_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [PHY_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [PHY_DW-1:0] rd_data,
  output logic              link_evt,
  output logic              an_restart
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [PHY_DW-1:0] regs [NUM_REGS];
  logic              link_q;

  assign link_evt   = (link_up != link_q);
  assign an_restart = wr_en && (wr_addr == '0) && wr_data[CTL_RESTART_BIT];
  assign rd_data    = regs[rd_addr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= phy_reset_value(i, link_up);
      link_q <= link_up;
    end else begin
      if (wr_en) begin
        if (wr_addr == '0) regs[0] <= ctrl_store_value(wr_data);
        else               regs[wr_addr[IDX_W-1:0]] <= wr_data;
      end
      if (an_restart) begin
        regs[1][STS_ANDONE_BIT] <= 1'b1;
        if (link_up) begin
          regs[1][STS_LINK_BIT]  <= 1'b1;
          regs[5][LPA_FD100_BIT] <= 1'b1;
        end
      end
      if (link_evt) begin
        regs[1][STS_LINK_BIT]  <= link_up;
        regs[5][LPA_FD100_BIT] <= link_up;
      end
      link_q <= link_up;
    end
  end

endmodule

// File: rtl/mii_mgmt_unit.sv
module mii_mgmt_unit
  import mii_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int         NUM_REGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  host_sel_e         sel;
  mgmt_cmd_t         cmd;
  logic              frame_wr;
  logic              cmd_accept;
  logic              phy_wr;
  logic              phy_rd;
  logic              link_evt;
  logic              an_restart;
  logic              stat_rd;
  logic [PHY_DW-1:0] phy_rdata;
  logic [31:0]       frame_q;
  logic [31:0]       cfg_q;
  logic [15:0]       stat_q;

  assign sel      = host_sel_e'(addr);
  assign cmd      = mgmt_cmd_t'(wdata);
  assign frame_wr = wr_en && (sel == SEL_FRAME);
  assign stat_rd  = rd_en && (sel == SEL_STAT);

  mii_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .frame_wr (frame_wr),
    .st       (cmd.st),
    .op       (cmd.op),
    .phy      (cmd.phy),
    .accept   (cmd_accept),
    .phy_wr   (phy_wr),
    .phy_rd   (phy_rd)
  );

  mii_phy_regs #(.NUM_REGS(NUM_REGS)) u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .wr_en      (phy_wr),
    .wr_addr    (cmd.ra),
    .wr_data    (cmd.data),
    .rd_addr    (cmd.ra),
    .rd_data    (phy_rdata),
    .link_evt   (link_evt),
    .an_restart (an_restart)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      cfg_q   <= CFG_RESET;
      stat_q  <= '0;
    end else begin
      if (frame_wr)
        frame_q <= {wdata[31:17], 1'b1, (phy_rd ? phy_rdata : cmd.data)};
      if (wr_en && (sel == SEL_CFG))
        cfg_q <= cfg_merge(cfg_q, wdata);
      if (link_evt)     stat_q <= 16'hFFFF;
      else if (stat_rd) stat_q <= '0;
    end
  end

  always_comb begin
    case (sel)
      SEL_FRAME: rdata = frame_q;
      SEL_CFG:   rdata = cfg_q;
      SEL_STAT:  rdata = {16'h0000, stat_q};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/mii_mgmt_unit_chk.sv
module mii_mgmt_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] frame_q,
  input logic [31:0] cfg_q,
  input logic [15:0] stat_q,
  input logic        phy_wr,
  input logic        phy_rd,
  input logic        link_evt
);

  // R3: a command is a read or a write, never both
  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_wr, phy_rd}));

  // R2: completion flag after every frame write
  a_r2_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> frame_q[16]);

  // R4: data field kept unless the word is a read command
  a_r4_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[29:28] != 2'b10) |=> (frame_q[15:0] == $past(wdata[15:0])));

  // R1: badly framed words never reach the register file
  a_r1_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[31:30] != 2'b01) |-> !(phy_wr || phy_rd));

  // R8: transceiver bits hold across config writes
  a_r8_cfg_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (cfg_q[9:8] == $past(cfg_q[9:8])));

  // R9: link change raises the event word
  a_r9_link_event: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up != $past(link_up)) |=> (stat_q == 16'hFFFF));

  // R10: status read clears when no event competes
  a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !link_evt) |=> (stat_q == 16'h0000));

endmodule

bind mii_mgmt_unit mii_mgmt_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .link_up  (link_up),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .frame_q  (frame_q),
  .cfg_q    (cfg_q),
  .stat_q   (stat_q),
  .phy_wr   (phy_wr),
  .phy_rd   (phy_rd),
  .link_evt (link_evt)
);

// File: tb/mii_mgmt_unit_tb.sv
module mii_mgmt_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;

  logic [15:0] phy_m [32];
  logic        link_m;
  logic [31:0] cfg_m;
  logic [15:0] stat_m;

  always #5 clk = ~clk;

  mii_mgmt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] build(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] ra,
                                        input logic [1:0] ta, input logic [15:0] d);
    return {st, op, phy, ra, ta, d};
  endfunction

  task automatic model_phy_write(input logic [4:0] ra, input logic [15:0] d);
    logic [15:0] v;
    v = d;
    if (ra == 5'd0) begin
      if (v[15]) begin v[15] = 1'b0; v[12] = 1'b1; end
      if (v[9]) begin
        v[9] = 1'b0;
        phy_m[1][5] = 1'b1;
        if (link_m) begin phy_m[1][2] = 1'b1; phy_m[5][8] = 1'b1; end
      end
    end
    phy_m[ra] = v;
  endtask

  task automatic mgmt(input string req, input logic [31:0] w);
    logic [31:0] got, exp;
    logic ok;
    ok = (w[31:30] == 2'b01) && (w[27:23] == 5'd1);
    exp = w;
    exp[16] = 1'b1;
    if (ok && w[29:28] == 2'b10) exp[15:0] = phy_m[w[22:18]];
    host_wr(2'd0, w);
    if (ok && w[29:28] == 2'b01) model_phy_write(w[22:18], w[15:0]);
    host_rd(2'd0, got);
    check(req, got, exp);
  endtask

  task automatic phy_read_check(input string req, input logic [4:0] ra);
    mgmt(req, build(2'b01, 2'b10, 5'd1, ra, 2'b00, 16'h0000));
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    if (v != link_m) begin
      link_m = v;
      phy_m[1][2] = v;
      phy_m[5][8] = v;
      stat_m = 16'hFFFF;
    end
    @(posedge clk); #1;
  endtask

  task automatic stat_check(input string req);
    logic [31:0] got;
    host_rd(2'd2, got);
    check(req, got, {16'h0, stat_m});
    stat_m = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    link_m = 1'b1;
    for (int i = 0; i < 32; i++) phy_m[i] = 16'h0;
    phy_m[1] = 16'h402C;
    phy_m[4] = 16'h0100;
    phy_m[5] = 16'h0100;
    cfg_m = 32'h100;
    stat_m = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 / R8 / R10: reset state
    host_rd(2'd0, got); check("R7 frame reset", got, 32'h0);
    host_rd(2'd1, got); check("R8 cfg reset", got, 32'h100);
    host_rd(2'd2, got); check("R10 stat reset", got, 32'h0);
    host_rd(2'd3, got); check("R8 unused address", got, 32'h0);
    for (int i = 0; i < 8; i++) phy_read_check("R7 phy reset", 5'(i));

    // R1: bad start and bad PHY address leave register 3 alone
    mgmt("R1 bad start", build(2'b11, 2'b01, 5'd1, 5'd3, 2'b00, 16'hBEEF));
    mgmt("R1 bad phy", build(2'b01, 2'b01, 5'd0, 5'd3, 2'b10, 16'hCAFE));
    phy_read_check("R1 reg3 untouched", 5'd3);

    // R3 write and read back, R2 turnaround MSB kept
    mgmt("R3 write", build(2'b01, 2'b01, 5'd1, 5'd7, 2'b10, 16'h1234));
    phy_read_check("R3 readback", 5'd7);

    // R4 opcodes 00 and 11
    mgmt("R4 op00", build(2'b01, 2'b00, 5'd1, 5'd7, 2'b00, 16'h5555));
    mgmt("R4 op11", build(2'b01, 2'b11, 5'd1, 5'd7, 2'b00, 16'hAAAA));
    phy_read_check("R4 reg7 unchanged", 5'd7);

    // R5 reset bit
    mgmt("R5 ctrl reset", build(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h8000));
    phy_read_check("R5 ctrl value", 5'd0);

    // R6 restart with link up
    mgmt("R6 clr1", build(2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h0000));
    mgmt("R6 clr5", build(2'b01, 2'b01, 5'd1, 5'd5, 2'b00, 16'h0000));
    mgmt("R6 restart up", build(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h0200));
    phy_read_check("R6 reg0", 5'd0);
    phy_read_check("R6 reg1 up", 5'd1);
    phy_read_check("R6 reg5 up", 5'd5);

    // R9 link down, R10 clear on read
    set_link(1'b0);
    stat_check("R9 event word");
    stat_check("R10 cleared");
    phy_read_check("R9 reg1 down", 5'd1);
    phy_read_check("R9 reg5 down", 5'd5);

    // R6 restart with link down
    mgmt("R6 clr1b", build(2'b01, 2'b01, 5'd1, 5'd1, 2'b00, 16'h0000));
    mgmt("R6 restart down", build(2'b01, 2'b01, 5'd1, 5'd0, 2'b00, 16'h0200));
    phy_read_check("R6 reg1 down", 5'd1);
    phy_read_check("R6 reg5 down", 5'd5);

    // R8 read-only configuration bits
    host_wr(2'd1, 32'h0); host_rd(2'd1, got); check("R8 cfg zero write", got, 32'h100);
    host_wr(2'd1, 32'hFFFF_FFFF); host_rd(2'd1, got); check("R8 cfg ones write", got, 32'hFFFF_FDFF);
    cfg_m = 32'hFFFF_FDFF;

    // R10: link change in the same cycle as the status read wins
    @(negedge clk);
    addr = 2'd2; rd_en = 1'b1; link_up = 1'b1;
    #1 got = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
    check("R10 read returns old", got, 32'h0);
    link_m = 1'b1; phy_m[1][2] = 1'b1; phy_m[5][8] = 1'b1; stat_m = 16'hFFFF;
    stat_check("R10 event wins");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) begin
        set_link(~link_m);
        stat_check("R9 random event");
      end else if (r == 1) begin
        logic [31:0] w;
        w = $urandom;
        host_wr(2'd1, w);
        cfg_m = (w & ~32'h300) | (cfg_m & 32'h300);
        host_rd(2'd1, got);
        check("R8 random cfg", got, cfg_m);
      end else begin
        logic [1:0] st;
        logic [4:0] phy, ra;
        st  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
        phy = ($urandom % 4 == 0) ? 5'($urandom) : 5'd1;
        ra  = ($urandom % 2 == 0) ? 5'($urandom % 8) : 5'($urandom);
        mgmt("R3 random op", build(st, 2'($urandom), phy, ra, 2'($urandom), 16'($urandom)));
      end
    end

    for (int i = 0; i < 32; i++) phy_read_check("R3 final sweep", 5'(i));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule